// File: doc/BRIEF.md
# Adaptive Pulse-and-Verify Burn Sequencer

This controller writes a full image into a byte-wide memory whose cells can only be cleared to zero by program pulses. It steps through the addresses in ascending order. At each address it fetches the intended byte from a source port and applies one fixed-length program pulse. It then waits a settle interval and reads the byte back. If the read-back differs, it pulses the same address again. It gives up on that address once a pulse budget is spent. The number of pulses therefore adapts per address: easy cells take one pulse, stubborn cells take more.

After the last address verifies, the controller drops both supply-select flags to the normal level. It then reads the whole array once more and compares every byte against the source image. A `start` pulse launches a run. `done` marks the end of every run, whether it succeeds or fails. `fail` and `fail_addr` report the address that ran out of pulses, or else the first address that mismatched in the final pass. The supply voltages themselves are outside the block. They appear only as two select flags.

Top module: `pulse_verify_programmer`

## Requirements
- R1: Every program pulse holds `mem_burn_n` low for exactly CLK_MHZ*PULSE_US consecutive cycles. For the whole pulse, `mem_sel_n` is low, `mem_rd_n` is high, and both `prog_supply_hi` and `core_supply_hi` are high.
- R2: While `mem_rd_n` is low, `mem_burn_n` is high and `mem_sel_n` is low. The read-back compare happens SETTLE_CYC+1 cycles after a pulse ends, and a matching byte finishes that address.
- R3: A mismatching read-back leads to another pulse on the same address. No address receives more than MAX_PULSES pulses.
- R4: Pulses begin at address 0. Each new pulse is either on the address of the previous pulse or on the next higher one. The byte programmed at an address is `src_data` as returned for `src_addr` equal to that address.
- R5: If an address has received MAX_PULSES pulses and still mismatches, the run ends with `done`=1, `fail`=1 and `fail_addr` equal to that address. No further address is pulsed.
- R6: In the final pass both supply flags are low. Every address from 0 to the last is read and compared against `src_data`. The lowest mismatching address sets `fail`=1 and is placed in `fail_addr`, and the scan still runs to the last address.
- R7: `done` stays high from the end of a run until a new `start` is accepted. A new start clears `done`, `fail` and `fail_addr` on the next cycle.
- R8: The run takes, from the edge that samples `start` to the edge that raises `done`, the sum over programmed addresses of 1+p*(PULSE+SETTLE_CYC+1) cycles, where p is the pulses used. A run that reaches the final pass adds 2^ADDR_W*(SETTLE_CYC+1) cycles.
- R9: During and after reset, and whenever `done` is high or no run is active, `mem_sel_n`, `mem_rd_n` and `mem_burn_n` are high, both supply flags are low, and `done` and `fail` are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a run when idle or done |
| done | output | 1 | Run finished (level) |
| fail | output | 1 | Run ended with an error |
| fail_addr | output | ADDR_W | Address of the reported error |
| src_addr | output | ADDR_W | Address of the image byte requested |
| src_data | input | DATA_W | Image byte for `src_addr`, same cycle |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Byte driven to the memory for programming |
| mem_rdata | input | DATA_W | Byte read from the memory |
| mem_sel_n | output | 1 | Memory select, active low |
| mem_rd_n | output | 1 | Memory output drive, active low |
| mem_burn_n | output | 1 | Program strobe, active low |
| prog_supply_hi | output | 1 | Selects the raised programming supply |
| core_supply_hi | output | 1 | Selects the raised core supply |

## Verification
The bench builds the block with ADDR_W=3, CLK_MHZ=1, PULSE_US=100, MAX_PULSES=4 and SETTLE_CYC=3. These values give 100-cycle pulses and eight addresses. With them, a complete run, an exhausted pulse budget at the first, middle and last address, and final-pass corruption at several addresses all fit in a short run. Each can be compared against an exact cycle count and exact per-address pulse counts.

// File: rtl/pvp_pkg.sv
package pvp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_PULSE, ST_SETTLE,
    ST_CHECK, ST_FV_SETTLE, ST_FV_CHECK, ST_DONE
  } pvp_state_e;

  // cycles spent in one program pulse
  function automatic int pulse_cycles(int clk_mhz, int pulse_us);
    return clk_mhz * pulse_us;
  endfunction

  // counter width able to hold the larger of two reload values
  function automatic int timer_width(int a, int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/pvp_timer.sv
module pvp_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pvp_pulse_ctr.sv
module pvp_pulse_ctr #(
  parameter int MAXP = 25,
  localparam int W = (MAXP < 2) ? 1 : $clog2(MAXP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (inc)      cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit = (cnt_q == W'(MAXP));

  // R3
  no_extra_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_limit);
endmodule

// File: rtl/pulse_verify_programmer.sv
module pulse_verify_programmer
  import pvp_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int CLK_MHZ    = 200,
  parameter int PULSE_US   = 100,
  parameter int MAX_PULSES = 25,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_sel_n,
  output logic              mem_rd_n,
  output logic              mem_burn_n,
  output logic              prog_supply_hi,
  output logic              core_supply_hi
);
  localparam int PULSE_CYC = pulse_cycles(CLK_MHZ, PULSE_US);
  localparam int TMR_W     = timer_width(PULSE_CYC, SETTLE_CYC);
  localparam logic [TMR_W-1:0]  PULSE_VAL  = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0]  SETTLE_VAL = TMR_W'(SETTLE_CYC - 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR  = {ADDR_W{1'b1}};

  pvp_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wbuf_q;
  logic              fail_q;
  logic [ADDR_W-1:0] fail_addr_q;

  // named internal events
  logic tmr_load, tmr_zero, pc_clr, pc_inc, at_limit;
  logic [TMR_W-1:0] tmr_val;
  logic start_ok, addr_clr, addr_adv, latch, give_up, fv_miss, match, last;

  pvp_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero));

  pvp_pulse_ctr #(.MAXP(MAX_PULSES)) u_pcnt (
    .clk(clk), .rst_n(rst_n), .clr(pc_clr), .inc(pc_inc), .at_limit(at_limit));

  assign last  = (addr_q == LAST_ADDR);
  assign match = (mem_rdata == ((st_q == ST_FV_CHECK) ? src_data : wbuf_q));

  always_comb begin
    st_d = st_q;
    tmr_load = 1'b0; tmr_val = '0;
    pc_clr = 1'b0; pc_inc = 1'b0;
    start_ok = 1'b0; addr_clr = 1'b0; addr_adv = 1'b0;
    latch = 1'b0; give_up = 1'b0; fv_miss = 1'b0;
    case (st_q)
      ST_IDLE, ST_DONE: if (start) begin
        start_ok = 1'b1; addr_clr = 1'b1; st_d = ST_LOAD;
      end
      ST_LOAD: begin
        latch = 1'b1; pc_clr = 1'b1;
        tmr_load = 1'b1; tmr_val = PULSE_VAL; st_d = ST_PULSE;
      end
      ST_PULSE: if (tmr_zero) begin
        pc_inc = 1'b1; tmr_load = 1'b1; tmr_val = SETTLE_VAL; st_d = ST_SETTLE;
      end
      ST_SETTLE: if (tmr_zero) st_d = ST_CHECK;
      ST_CHECK: begin
        if (match) begin
          if (last) begin
            addr_clr = 1'b1; tmr_load = 1'b1; tmr_val = SETTLE_VAL;
            st_d = ST_FV_SETTLE;
          end else begin
            addr_adv = 1'b1; st_d = ST_LOAD;
          end
        end else if (at_limit) begin
          give_up = 1'b1; st_d = ST_DONE;
        end else begin
          tmr_load = 1'b1; tmr_val = PULSE_VAL; st_d = ST_PULSE;
        end
      end
      ST_FV_SETTLE: if (tmr_zero) st_d = ST_FV_CHECK;
      ST_FV_CHECK: begin
        fv_miss = !match;
        if (last) st_d = ST_DONE;
        else begin
          addr_adv = 1'b1; tmr_load = 1'b1; tmr_val = SETTLE_VAL;
          st_d = ST_FV_SETTLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; addr_q <= '0; wbuf_q <= '0;
      fail_q <= 1'b0; fail_addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (addr_clr)      addr_q <= '0;
      else if (addr_adv) addr_q <= addr_q + 1'b1;
      if (latch) wbuf_q <= src_data;
      if (start_ok) begin
        fail_q <= 1'b0; fail_addr_q <= '0;
      end else if (give_up || (fv_miss && !fail_q)) begin
        fail_q <= 1'b1; fail_addr_q <= addr_q;
      end
    end
  end

  logic active, prog_phase;
  assign active     = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign prog_phase = (st_q == ST_LOAD) || (st_q == ST_PULSE) ||
                      (st_q == ST_SETTLE) || (st_q == ST_CHECK);

  assign done           = (st_q == ST_DONE);
  assign fail           = fail_q;
  assign fail_addr      = fail_addr_q;
  assign src_addr       = addr_q;
  assign mem_addr       = addr_q;
  assign mem_wdata      = wbuf_q;
  assign mem_sel_n      = !active;
  assign mem_burn_n     = (st_q != ST_PULSE);
  assign mem_rd_n       = !((st_q == ST_SETTLE) || (st_q == ST_CHECK) ||
                            (st_q == ST_FV_SETTLE) || (st_q == ST_FV_CHECK));
  assign prog_supply_hi = prog_phase;
  assign core_supply_hi = prog_phase;

  // R1
  burn_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_burn_n |-> (mem_rd_n && !mem_sel_n && prog_supply_hi));
  // R1
  pulse_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_burn_n) |=> !mem_burn_n);
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_adv |=> (mem_addr == $past(mem_addr) + 1'b1));
  // R5
  give_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    give_up |=> (done && fail && fail_addr == $past(mem_addr)));
  // R6
  fv_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fv_miss |-> (!prog_supply_hi && !core_supply_hi && !mem_rd_n));
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: tb/pulse_verify_programmer_bench.sv
module pulse_verify_programmer_bench;
  localparam int AW = 3, DW = 8, MHZ = 1, PUS = 100, MAXP = 4, SET = 3;
  localparam int N = 1 << AW;
  localparam int P = PUS * MHZ;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, done, fail;
  logic [AW-1:0] fail_addr, src_addr, mem_addr;
  logic [DW-1:0] src_data, mem_wdata, mem_rdata;
  logic sel_n, rd_n, burn_n, ps_hi, cs_hi;

  pulse_verify_programmer #(.ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(MHZ), .PULSE_US(PUS),
    .MAX_PULSES(MAXP), .SETTLE_CYC(SET)) u_pulse_verify_programmer (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .fail(fail),
    .fail_addr(fail_addr), .src_addr(src_addr), .src_data(src_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_sel_n(sel_n), .mem_rd_n(rd_n), .mem_burn_n(burn_n),
    .prog_supply_hi(ps_hi), .core_supply_hi(cs_hi));

  logic [DW-1:0] image [N];
  logic [DW-1:0] stored [N];
  logic [DW-1:0] corrupt [N];
  int need [N];
  int pcount [N];
  int checks = 0, errors = 0;
  bit finished = 0;

  assign src_data = image[src_addr];
  always_comb begin
    if (!sel_n && !rd_n) mem_rdata = stored[mem_addr] ^ (cs_hi ? 8'h00 : corrupt[mem_addr]);
    else                 mem_rdata = 8'h00;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model and per-clock monitor
  int plow = 0, last_a = 0;
  bit prev_burn = 1'b1, first_pulse = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!burn_n) begin
        chk(!sel_n && rd_n && ps_hi && cs_hi, "R1 strobes", {sel_n, rd_n, ps_hi, cs_hi}, 4'b0111);
        if (prev_burn) begin
          if (first_pulse) chk(mem_addr == 0, "R4 first", int'(mem_addr), 0);
          else chk(mem_addr == last_a[AW-1:0] || int'(mem_addr) == last_a + 1,
                   "R4 order", int'(mem_addr), last_a);
          first_pulse = 1'b0;
          last_a = int'(mem_addr);
        end
        plow++;
      end else if (!prev_burn) begin
        chk(plow == P, "R1 width", plow, P);
        pcount[last_a]++;
        if (pcount[last_a] >= need[last_a]) stored[last_a] = stored[last_a] & mem_wdata;
        plow = 0;
      end
      if (!rd_n) chk(burn_n && !sel_n, "R2 read strobes", {burn_n, sel_n}, 2'b10);
      if (!rd_n && !ps_hi) chk(!cs_hi, "R6 supply", int'(cs_hi), 0);
      prev_burn = burn_n;
    end
  end

  task automatic erase();
    for (int a = 0; a < N; a++) begin
      stored[a] = 8'hFF; pcount[a] = 0; corrupt[a] = 8'h00;
    end
    first_pulse = 1'b1;
  endtask

  task automatic run_case(string name);
    int cyc = 0, eaddr = 0, cnt = 0, p;
    bit efail = 0, stopped = 0;
    int epulse [N];
    for (int a = 0; a < N; a++) begin
      epulse[a] = 0;
      if (!stopped) begin
        p = (image[a] == 8'hFF) ? 1 : ((need[a] > MAXP) ? MAXP : need[a]);
        epulse[a] = p;
        cyc += 1 + p * (P + SET + 1);
        if (image[a] != 8'hFF && need[a] > MAXP) begin
          efail = 1; eaddr = a; stopped = 1;
        end
      end
    end
    if (!stopped) begin
      cyc += N * (SET + 1);
      for (int a = 0; a < N; a++)
        if (corrupt[a] != 0 && !efail) begin efail = 1; eaddr = a; end
    end
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    chk(!done && !fail, {"R7 cleared ", name}, {done, fail}, 0);
    while (!done && cnt < 20000) begin
      cnt++;
      @(negedge clk);
    end
    chk(done == 1'b1, {"R7 done ", name}, int'(done), 1);
    chk(cnt == cyc, {"R8 cycles ", name}, cnt, cyc);
    chk(fail == efail, {"R5/R6 fail ", name}, int'(fail), int'(efail));
    if (efail) chk(int'(fail_addr) == eaddr, {"R5/R6 fail_addr ", name}, int'(fail_addr), eaddr);
    for (int a = 0; a < N; a++)
      chk(pcount[a] == epulse[a], {"R3 pulses ", name}, pcount[a], epulse[a]);
    if (!stopped)
      for (int a = 0; a < N; a++)
        chk(stored[a] == image[a], {"R4 image ", name}, int'(stored[a]), int'(image[a]));
    repeat (5) @(negedge clk);
    chk(done && sel_n && rd_n && burn_n && !ps_hi && !cs_hi, {"R9 R7 idle ", name},
        {done, sel_n, rd_n, burn_n, ps_hi, cs_hi}, 6'b111100);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    image = '{8'h00, 8'hA5, 8'h3C, 8'hFF, 8'h81, 8'h7E, 8'h10, 8'hEF};
    need  = '{1, 2, 3, 1, 4, 1, 2, 3};
    erase();
    repeat (3) @(negedge clk);
    chk(!done && !fail && sel_n && rd_n && burn_n && !ps_hi && !cs_hi, "R9 in reset",
        {done, fail, sel_n, rd_n, burn_n, ps_hi, cs_hi}, 7'b0011100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && sel_n && rd_n && burn_n && !ps_hi, "R9 after reset",
        {done, sel_n, rd_n, burn_n, ps_hi}, 5'b01110);

    // R2 R3 R4: mixed pulse demand, clean pass
    run_case("pass");
    // R5: budget exhausted mid-array
    erase(); need[5] = 6;
    run_case("limit_mid");
    // R6: corruption seen only in final pass, first of two reported
    erase(); need = '{2, 2, 2, 2, 2, 2, 2, 2};
    corrupt[6] = 8'h80; corrupt[2] = 8'h01;
    run_case("fv_miss");
    // R5: first address exhausts
    erase(); need[0] = 9;
    run_case("limit_first");
    // R5: last address exhausts, erased-value byte elsewhere takes one pulse
    erase(); need = '{9, 1, 1, 9, 1, 1, 1, 5};
    image[0] = 8'hFF;
    run_case("limit_last");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule